// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pullup Gating

This block is an eight-bit general-purpose I/O port attached to a simple processor register bus. Software sees three registers: a data latch, a direction register and a pullup enable register. Toward the pad ring the port drives a per-pin output enable, an output value and a pullup request.

A write to the data offset always lands in the latch, whatever the direction bits hold. Software can therefore preload an output value and only then turn the pin into an output, so no glitch reaches the pad. A read of the data offset is assembled bit by bit. An output bit returns its latch value. An input bit returns the pad level after a two-flop synchronizer.

The pullup request for a pin is granted only while that pin is an input and its pullup bit is set. Turning the pin into an output withdraws the pullup in the same cycle, with no software action.

Top module: `gpio_port`

## Requirements
- R1: Synchronous reset clears the data latch, the direction register, the pullup register and the synchronizer, so after reset pad_oe, pad_out and pad_pu are all zero and every register reads 0x00.
- R2: A write to offset 0x00 updates the data latch at the next clock edge, whatever the direction bits hold, and pad_out always equals the latch.
- R3: pad_oe for each pin equals that pin's direction bit, and a write to offset 0x04 changes it at the next clock edge.
- R4: Offset 0x04 reads back all eight direction bits as written.
- R5: Offset 0x08 is the pullup enable register, one bit per pin, readable and writable across all eight bits.
- R6: pad_pu of a pin is 1 only when its pullup bit is 1 and its direction bit is 0. While the direction bit is 1, pad_pu is 0 whatever the pullup bit holds. A pin with both bits at 0 has pad_oe and pad_pu both 0 (a high-impedance input).
- R7: A read of offset 0x00 returns, for each bit, the latch value when the direction bit is 1. When the direction bit is 0 it returns the pad_in level sampled two clock edges earlier.
- R8: Reads of any offset other than 0x00, 0x04 and 0x08 return 0x00, and writes to them leave pad_out, pad_oe, pad_pu and all register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Output value toward the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin pullup request |

## Verification
On every cycle the assertions check four things. A pullup and an output enable are never active together on one pin. Data and direction writes show on the pads one edge later. Unmapped writes change nothing and unmapped reads return zero. Output bits of a data read always match the latch.

Only the bench's reference model can show the rest. It checks the two-edge lag of input bits through the synchronizer and the bit-by-bit mix of latch and pin values under changing pad patterns. It also checks that the latch keeps a value preloaded while the pins were inputs, and that the pullup returns when a pin goes back to input.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int OFS_DATA = 'h00;
    localparam int OFS_DIR  = 'h04;
    localparam int OFS_PUE  = 'h08;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_PUE
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pin_drive_t;

    function automatic reg_sel_e decode_offset(input int unsigned ofs);
        reg_sel_e s;
        if (ofs == OFS_DATA)      s = SEL_DATA;
        else if (ofs == OFS_DIR)  s = SEL_DIR;
        else if (ofs == OFS_PUE)  s = SEL_PUE;
        else                      s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode #(
    parameter int AW = 8
) (
    input  logic              [AW-1:0] addr,
    input  logic                       wr,
    output gpio_pkg::reg_sel_e         sel,
    output logic                       we_data,
    output logic                       we_dir,
    output logic                       we_pue
);
    import gpio_pkg::*;

    always_comb begin
        sel     = decode_offset(int'(unsigned'(addr)));
        we_data = wr && (sel == SEL_DATA);
        we_dir  = wr && (sel == SEL_DIR);
        we_pue  = wr && (sel == SEL_PUE);
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_data,
    input  logic         we_dir,
    input  logic         we_pue,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pue_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            pue_q   <= '0;
        end else begin
            if (we_data) latch_q <= wdata;
            if (we_dir)  dir_q   <= wdata;
            if (we_pue)  pue_q   <= wdata;
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_in[i]};
        end
        assign sync_out[i] = chain[LAST];
    end
endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl #(
    parameter int W = 8
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pue_q,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] data_view
);
    import gpio_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_drive_t drv;
        always_comb begin
            drv.oe  = dir_q[i];
            drv.out = latch_q[i];
            drv.pu  = pue_q[i] & ~dir_q[i];
        end
        assign pad_oe[i]    = drv.oe;
        assign pad_out[i]   = drv.out;
        assign pad_pu[i]    = drv.pu;
        assign data_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int W      = 8,
    parameter int AW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_pu
);
    import gpio_pkg::*;

    reg_sel_e     sel;
    logic         we_data, we_dir, we_pue;
    logic [W-1:0] latch_q, dir_q, pue_q;
    logic [W-1:0] pin_sync, data_view;

    gpio_decode #(.AW(AW)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .sel     (sel),
        .we_data (we_data),
        .we_dir  (we_dir),
        .we_pue  (we_pue)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_data (we_data),
        .we_dir  (we_dir),
        .we_pue  (we_pue),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pue_q   (pue_q)
    );

    gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_pinctl #(.W(W)) u_pin (
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .pue_q     (pue_q),
        .pin_sync  (pin_sync),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .data_view (data_view)
    );

    always_comb begin
        unique case (sel)
            SEL_DATA: bus_rdata = data_view;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_PUE:  bus_rdata = pue_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W  = 8,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  pad_out,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  pad_pu
);
    import gpio_pkg::*;

    logic at_data, at_dir, at_pue, at_none;
    assign at_data = (int'(unsigned'(bus_addr)) == OFS_DATA);
    assign at_dir  = (int'(unsigned'(bus_addr)) == OFS_DIR);
    assign at_pue  = (int'(unsigned'(bus_addr)) == OFS_PUE);
    assign at_none = !(at_data || at_dir || at_pue);

    AST_PU_NEVER_WITH_OE: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0); // R6

    AST_PU_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
        bus_wr && at_pue |=> pad_pu == ($past(bus_wdata) & ~pad_oe)); // R5

    AST_DATA_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        bus_wr && at_data |=> pad_out == $past(bus_wdata)); // R2

    AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        bus_wr && at_dir |=> pad_oe == $past(bus_wdata)); // R3

    AST_DIR_READBACK: assert property (@(posedge clk) disable iff (rst)
        at_dir |-> bus_rdata == pad_oe); // R4

    AST_OUTPUT_BITS_READ_LATCH: assert property (@(posedge clk) disable iff (rst)
        at_data |-> (bus_rdata & pad_oe) == (pad_out & pad_oe)); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        at_none |-> bus_rdata == '0); // R8

    AST_UNMAPPED_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
        bus_wr && at_none |=> $stable(pad_out) && $stable(pad_oe) && $stable(pad_pu)); // R8
endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // behavioural reference
    int unsigned m_latch = 0, m_dir = 0, m_pue = 0;
    int unsigned pin_hist[$];
    int          since_rst = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_latch = 0; m_dir = 0; m_pue = 0;
            pin_hist = {};
            pin_hist.push_back(0);
            pin_hist.push_back(0);
            since_rst = 0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_latch = bus_wdata;
                    8'h04: m_dir   = bus_wdata;
                    8'h08: m_pue   = bus_wdata;
                    default: ;
                endcase
            end
            pin_hist.push_back(pad_in);
            void'(pin_hist.pop_front());
            since_rst++;
        end
    end

    function automatic int unsigned exp_rdata();
        int unsigned v;
        case (bus_addr)
            8'h00: begin
                v = 0;
                for (int b = 0; b < 8; b++)
                    v[b] = m_dir[b] ? m_latch[b] : pin_hist[0][b];
                return v;
            end
            8'h04:   return m_dir;
            8'h08:   return m_pue;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, expv, $time);
        end
    endtask

    // compare on every clock, one ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            string t_out, t_oe, t_pu, t_rd;
            int unsigned e_pu, e_rd;
            bit near_rst;
            near_rst = rst || since_rst == 0;
            t_out = near_rst ? "R1 pad_out" : "R2 pad_out";
            t_oe  = near_rst ? "R1 pad_oe"  : "R3 pad_oe";
            t_pu  = near_rst ? "R1 pad_pu"  : "R6 pad_pu";
            case (bus_addr)
                8'h00:   t_rd = "R7 data read";
                8'h04:   t_rd = "R4 dir read";
                8'h08:   t_rd = "R5 pue read";
                default: t_rd = "R8 unmapped read";
            endcase
            if (near_rst) t_rd = {"R1 ", t_rd};
            e_pu = m_pue & ~m_dir & 8'hFF;
            e_rd = exp_rdata();
            chk(pad_out == m_latch[7:0], t_out, pad_out, m_latch);
            chk(pad_oe  == m_dir[7:0],   t_oe,  pad_oe,  m_dir);
            chk(pad_pu  == e_pu[7:0],    t_pu,  pad_pu,  e_pu);
            chk(bus_rdata == e_rd[7:0],  t_rd,  bus_rdata, e_rd);
        end
    end

    task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d, input logic [7:0] p);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; pad_in = p;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] p;
        // R1: pad_in busy during reset must not leak
        step(8'h00, 1'b0, 8'h00, 8'hA5);
        step(8'h04, 1'b1, 8'hFF, 8'h5A);
        step(8'h00, 1'b0, 8'h00, 8'hFF);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(pad_oe == 8'h00 && pad_pu == 8'h00 && pad_out == 8'h00, "R1 reset outputs", {pad_oe, pad_pu, pad_out}, 0);
        step(8'h04, 1'b0, 8'h00, 8'hFF);
        #1; chk(bus_rdata == 8'h00, "R1 dir after reset", bus_rdata, 0);
        step(8'h08, 1'b0, 8'h00, 8'hFF);
        #1; chk(bus_rdata == 8'h00, "R1 pue after reset", bus_rdata, 0);
        // R7: input lag, all pins inputs
        step(8'h00, 1'b0, 8'h00, 8'h3C);
        step(8'h00, 1'b0, 8'h00, 8'hC3);
        step(8'h00, 1'b0, 8'h00, 8'h0F);
        step(8'h00, 1'b0, 8'h00, 8'h0F);
        #1; chk(bus_rdata == 8'hC3, "R7 two-edge lag", bus_rdata, 8'hC3);
        // R2: preload latch while inputs
        step(8'h00, 1'b1, 8'h96, 8'h00);
        step(8'h00, 1'b0, 8'h00, 8'h00);
        #1; chk(pad_out == 8'h96, "R2 preload", pad_out, 8'h96);
        // R6: pullups on inputs
        step(8'h08, 1'b1, 8'hFF, 8'h00);
        step(8'h08, 1'b0, 8'h00, 8'h00);
        #1; chk(pad_pu == 8'hFF, "R6 all pullups", pad_pu, 8'hFF);
        // R3, R6: half outputs drop pullups
        step(8'h04, 1'b1, 8'hF0, 8'h00);
        step(8'h00, 1'b0, 8'h00, 8'h55);
        #1; chk(pad_pu == 8'h0F, "R6 gated by dir", pad_pu, 8'h0F);
        // R7: mixed read over several pin patterns
        for (int k = 0; k < 40; k++) begin
            p = 8'(k * 37 + 11);
            step(8'h00, 1'b0, 8'h00, p);
        end
        // R8: unmapped writes and reads
        step(8'h0C, 1'b1, 8'h00, 8'h12);
        step(8'h01, 1'b1, 8'hFF, 8'h12);
        step(8'hFF, 1'b1, 8'h00, 8'h12);
        step(8'h05, 1'b0, 8'h00, 8'h12);
        #1; chk(pad_out == 8'h96 && pad_oe == 8'hF0 && pad_pu == 8'h0F, "R8 unmapped writes ignored",
                {pad_out, pad_oe, pad_pu}, {8'h96, 8'hF0, 8'h0F});
        // R3, R6: back to inputs restores pullups
        step(8'h04, 1'b1, 8'h00, 8'h12);
        step(8'h08, 1'b0, 8'h00, 8'h12);
        #1; chk(pad_pu == 8'hFF && pad_oe == 8'h00, "R6 pullups return", {pad_oe, pad_pu}, 8'hFF);
        // R5, R3: per-bit independence under a sweep
        for (int k = 0; k < 60; k++) begin
            step(8'((k % 4) * 4), 1'b1, 8'(k * 53 + 7), 8'(k * 29));
            step(8'((k % 3) * 4), 1'b0, 8'h00, 8'(k * 71));
        end
        // R2: latch write while all outputs
        step(8'h04, 1'b1, 8'hFF, 8'h00);
        step(8'h00, 1'b1, 8'h69, 8'hFF);
        step(8'h00, 1'b0, 8'h00, 8'hFF);
        #1; chk(bus_rdata == 8'h69 && pad_pu == 8'h00, "R7 outputs read latch", bus_rdata, 8'h69);
        step(8'h00, 1'b0, 8'h00, 8'h00);
        step(8'h00, 1'b0, 8'h00, 8'h00);
        finish_run();
    end
endmodule